// File: doc/BRIEF.md
# Residue-domain FIR tap with logarithmic multiplier

This block is one stage of a transposed-form FIR filter whose arithmetic runs in the residue field of a single prime modulus. Residues are multiplied in the logarithmic domain. Every nonzero residue is a power of a primitive root. The input sample arrives already converted to its exponent (its "index") together with a flag that marks the value zero. The coefficient is preloaded in the same form.

Inside the tap, the two indices are added modulo one less than the modulus. A table built from logic turns the sum back into a residue. That product is added, modulo the prime, to the partial sum coming from the neighbouring tap, and the result is registered.

The sample index and zero flag are broadcast to every tap of a filter. The partial sum runs from the far end of the chain towards the output. The tap at the far end receives zero as its incoming partial sum.

The modulus and root are parameters, and the exponent table is computed when the design is elaborated. Elaboration stops with an error if the modulus is not a prime of at least 3, or if the root is not primitive for it. When one less than the modulus is a power of two, an option replaces the index adder with plain wrap-around addition.

Top module: `rfir_tap`

## Requirements
- R1: While reset is asserted and at the first edge after it, `s_out` is 0. After reset the stored coefficient is marked zero, so until a load the tap passes `s_in` through unchanged.
- R2: At a rising edge with `coef_load` high, the tap stores `coef_idx_in` and `coef_zero_in`. With `coef_load` low, the stored coefficient keeps its value, whatever is on those inputs.
- R3: When both zero flags are clear, the product is ROOT^((coefficient index + sample index) mod (MODULUS−1)) mod MODULUS. With MODULUS = 5 and ROOT = 2, indices 3 and 2 give residue 2.
- R4: When either zero flag is set (the flag is 1 for the value zero, and the index is then ignored), the product is 0 and the next `s_out` equals `s_in`.
- R5: `s_out` changes only at a rising clock edge. After the edge it holds (product + `s_in`) mod MODULUS, formed from the inputs sampled at that edge.
- R6: Given `s_in` below MODULUS and indices below MODULUS−1, `s_out` is always below MODULUS.
- R7: Three taps in a chain give y(n) = (a0·x(n) + a1·x(n−1) + a2·x(n−2)) mod MODULUS at the output of the first tap. In this chain the last tap's `s_in` is 0, each tap's `s_in` is the next tap's `s_out`, and x is zero before the first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_load | input | 1 | Store the coefficient inputs at the next edge |
| coef_idx_in | input | WI | Coefficient index, range 0..MODULUS−2 |
| coef_zero_in | input | 1 | Coefficient is zero |
| x_idx | input | WI | Sample index, range 0..MODULUS−2, shared by all taps |
| x_zero | input | 1 | Sample is zero, shared by all taps |
| s_in | input | WR | Partial sum from the next tap (0 at the last tap) |
| s_out | output | WR | Registered partial sum towards the previous tap |

WR is the bit width of MODULUS−1, and WI is the bit width of MODULUS−2, each at least 1.

## Verification
A stand-alone tap is built with modulus 7 and root 3. Its index modulus, 6, is not a power of two, so both modular adders use the dual-adder select path. At this size every coefficient, sample and incoming sum (7×7×7) can be swept, which covers every pairing of zero and nonzero operands.

A three-tap chain is built with modulus 5 and root 2 and the wrap-around index adder enabled. This brings the folded variant, the example from R3 and the transposed delay behaviour within reach of a short sample stream.

// File: rtl/rfir_pkg.sv
package rfir_pkg;

   // Bit width needed to hold values 0..n, never less than one.
   function automatic int f_width(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

   // base^e mod m by repeated multiplication (elaboration only, small e).
   function automatic int f_pow_mod(input int base, input int e, input int m);
      int r;
      r = 1 % m;
      for (int i = 0; i < e; i++) r = (r * base) % m;
      return r;
   endfunction

   function automatic bit f_is_prime(input int n);
      if (n < 2) return 1'b0;
      for (int d = 2; d * d <= n; d++)
         if (n % d == 0) return 1'b0;
      return 1'b1;
   endfunction

   // q is primitive modulo prime m when no power below m-1 returns to 1.
   function automatic bit f_is_primitive(input int q, input int m);
      if (q % m == 0) return 1'b0;
      for (int k = 1; k < m - 1; k++)
         if (f_pow_mod(q % m, k, m) == 1) return 1'b0;
      return 1'b1;
   endfunction

endpackage

// File: rtl/rfir_modadd.sv
// Adds two residues modulo MOD. Dual-adder form: a+b and a+b-MOD are
// formed together and the sign of the second picks the result.
module rfir_modadd
   import rfir_pkg::*;
#(
   parameter int MOD       = 5,
   parameter int W         = 3,
   parameter bit FOLD_POW2 = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   localparam bit IS_POW2 = (MOD == (1 << W));
   localparam bit USE_WRAP = FOLD_POW2 && IS_POW2;

   if (MOD < 2) begin : g_bad_mod
      $error("rfir_modadd: MOD must be at least 2");
   end
   if (MOD > (1 << W)) begin : g_bad_width
      $error("rfir_modadd: W too narrow for MOD");
   end

   if (USE_WRAP) begin : g_wrap
      // Modulus equals 2^W: dropping the carry is the reduction.
      assign sum = W'(a + b);
   end else begin : g_dual
      logic [W:0]   raw;
      logic [W+1:0] trial;
      logic         neg;
      assign raw   = {1'b0, a} + {1'b0, b};
      assign trial = {1'b0, raw} - (W+2)'(MOD);
      assign neg   = trial[W+1];
      assign sum   = W'(neg ? {1'b0, raw} : trial);
   end
endmodule

// File: rtl/rfir_exp_table.sv
// Maps an index w to ROOT^w mod MOD. Contents are computed at elaboration.
module rfir_exp_table
   import rfir_pkg::*;
#(
   parameter int MOD  = 5,
   parameter int ROOT = 2,
   parameter int WI   = 2,
   parameter int WR   = 3
) (
   input  logic [WI-1:0] idx,
   output logic [WR-1:0] res
);
   localparam int DEPTH = 1 << WI;

   if (DEPTH < MOD - 1) begin : g_bad_depth
      $error("rfir_exp_table: WI too narrow for MOD-1 entries");
   end

   logic [WR-1:0] tbl [DEPTH];

   // Slots beyond MOD-2 are unreachable for legal indices; they hold 1
   // so the product path never yields 0 for a nonzero operand pair.
   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      localparam int VAL = (g < MOD - 1) ? f_pow_mod(ROOT, g, MOD) : 1;
      assign tbl[g] = WR'(VAL);
   end

   assign res = tbl[idx];
endmodule

// File: rtl/rfir_idx_mul.sv
// Product of two residues given by index and zero flag.
module rfir_idx_mul
   import rfir_pkg::*;
#(
   parameter int MOD       = 5,
   parameter int ROOT      = 2,
   parameter int WI        = 2,
   parameter int WR        = 3,
   parameter bit FOLD_POW2 = 1'b0
) (
   input  logic [WI-1:0] a_idx,
   input  logic          a_zero,
   input  logic [WI-1:0] b_idx,
   input  logic          b_zero,
   output logic [WR-1:0] prod
);
   logic [WI-1:0] idx_sum;
   logic [WR-1:0] pow_res;

   rfir_modadd #(
      .MOD       (MOD - 1),
      .W         (WI),
      .FOLD_POW2 (FOLD_POW2)
   ) u_idx_add (
      .a   (a_idx),
      .b   (b_idx),
      .sum (idx_sum)
   );

   rfir_exp_table #(
      .MOD  (MOD),
      .ROOT (ROOT),
      .WI   (WI),
      .WR   (WR)
   ) u_exp (
      .idx (idx_sum),
      .res (pow_res)
   );

   // Zero has no index: bypass the log path.
   assign prod = (a_zero || b_zero) ? '0 : pow_res;
endmodule

// File: rtl/rfir_tap.sv
module rfir_tap
   import rfir_pkg::*;
#(
   parameter int MODULUS   = 7,
   parameter int ROOT      = 3,
   parameter bit FOLD_POW2 = 1'b0,
   localparam int WR       = f_width(MODULUS - 1),
   localparam int WI       = f_width(MODULUS - 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          coef_load,
   input  logic [WI-1:0] coef_idx_in,
   input  logic          coef_zero_in,
   input  logic [WI-1:0] x_idx,
   input  logic          x_zero,
   input  logic [WR-1:0] s_in,
   output logic [WR-1:0] s_out
);
   if (MODULUS < 3 || !f_is_prime(MODULUS)) begin : g_bad_modulus
      $error("rfir_tap: MODULUS must be an odd prime");
   end
   if (!f_is_primitive(ROOT, MODULUS)) begin : g_bad_root
      $error("rfir_tap: ROOT is not a primitive root of MODULUS");
   end

   logic [WI-1:0] coef_idx_q;
   logic          coef_zero_q;
   logic [WR-1:0] prod;
   logic [WR-1:0] s_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef_idx_q  <= '0;
         coef_zero_q <= 1'b1;
      end else if (coef_load) begin
         coef_idx_q  <= coef_idx_in;
         coef_zero_q <= coef_zero_in;
      end
   end

   rfir_idx_mul #(
      .MOD       (MODULUS),
      .ROOT      (ROOT),
      .WI        (WI),
      .WR        (WR),
      .FOLD_POW2 (FOLD_POW2)
   ) u_mul (
      .a_idx  (coef_idx_q),
      .a_zero (coef_zero_q),
      .b_idx  (x_idx),
      .b_zero (x_zero),
      .prod   (prod)
   );

   rfir_modadd #(
      .MOD       (MODULUS),
      .W         (WR),
      .FOLD_POW2 (1'b0)
   ) u_acc (
      .a   (prod),
      .b   (s_in),
      .sum (s_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_out <= '0;
      else        s_out <= s_nxt;
   end
endmodule

// File: rtl/rfir_tap_chk.sv
module rfir_tap_chk #(
   parameter int MODULUS = 7,
   parameter int WI      = 3,
   parameter int WR      = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          coef_load,
   input logic [WI-1:0] coef_idx_in,
   input logic          coef_zero_in,
   input logic          x_zero,
   input logic [WR-1:0] s_in,
   input logic [WR-1:0] s_out,
   input logic [WI-1:0] coef_idx_q,
   input logic          coef_zero_q,
   input logic [WR-1:0] prod
);
   // R1: output still cleared at the first edge after release
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> s_out == '0);

   // R2: load captures both coefficient fields
   a_r2_coef_load: assert property (@(posedge clk) disable iff (!rst_n)
      coef_load |=> (coef_idx_q == $past(coef_idx_in)) && (coef_zero_q == $past(coef_zero_in)));

   // R2: without load the coefficient is held
   a_r2_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !coef_load |=> $stable(coef_idx_q) && $stable(coef_zero_q));

   // R3: nonzero field elements multiply to a nonzero residue
   a_r3_nonzero_product: assert property (@(posedge clk) disable iff (!rst_n)
      !(x_zero || coef_zero_q) |-> (prod != '0) && (prod < WR'(MODULUS)));

   // R4: a zero operand lets the partial sum through unchanged
   a_r4_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (x_zero || coef_zero_q) |=> s_out == $past(s_in));

   // R6: legal partial sum in gives legal residue out
   a_r6_out_range: assert property (@(posedge clk) disable iff (!rst_n)
      (s_in < WR'(MODULUS)) |=> s_out < WR'(MODULUS));
endmodule

bind rfir_tap rfir_tap_chk #(
   .MODULUS (MODULUS),
   .WI      (WI),
   .WR      (WR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .coef_load    (coef_load),
   .coef_idx_in  (coef_idx_in),
   .coef_zero_in (coef_zero_in),
   .x_zero       (x_zero),
   .s_in         (s_in),
   .s_out        (s_out),
   .coef_idx_q   (coef_idx_q),
   .coef_zero_q  (coef_zero_q),
   .prod         (prod)
);

// File: tb/rfir_tap_tb_top.sv
module rfir_tap_tb_top;
   localparam int M1 = 7;
   localparam int Q1 = 3;
   localparam int M2 = 5;
   localparam int Q2 = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n;
   logic       ld;
   logic [2:0] cidx;
   logic       czero;
   logic [2:0] xi;
   logic       xz;
   logic [2:0] si;
   logic [2:0] so;

   logic [2:0] cld;
   logic [1:0] cc_idx;
   logic       cc_zero;
   logic [1:0] cx_idx;
   logic       cx_zero;
   logic [2:0] c_s0, c_s1, c_s2;

   int checks = 0;
   int fails  = 0;

   rfir_tap #(.MODULUS(M1), .ROOT(Q1)) dut_i (
      .clk(clk), .rst_n(rst_n), .coef_load(ld), .coef_idx_in(cidx),
      .coef_zero_in(czero), .x_idx(xi), .x_zero(xz), .s_in(si), .s_out(so));

   rfir_tap #(.MODULUS(M2), .ROOT(Q2), .FOLD_POW2(1'b1)) tap0_i (
      .clk(clk), .rst_n(rst_n), .coef_load(cld[0]), .coef_idx_in(cc_idx),
      .coef_zero_in(cc_zero), .x_idx(cx_idx), .x_zero(cx_zero), .s_in(c_s1), .s_out(c_s0));
   rfir_tap #(.MODULUS(M2), .ROOT(Q2), .FOLD_POW2(1'b1)) tap1_i (
      .clk(clk), .rst_n(rst_n), .coef_load(cld[1]), .coef_idx_in(cc_idx),
      .coef_zero_in(cc_zero), .x_idx(cx_idx), .x_zero(cx_zero), .s_in(c_s2), .s_out(c_s1));
   rfir_tap #(.MODULUS(M2), .ROOT(Q2), .FOLD_POW2(1'b1)) tap2_i (
      .clk(clk), .rst_n(rst_n), .coef_load(cld[2]), .coef_idx_in(cc_idx),
      .coef_zero_in(cc_zero), .x_idx(cx_idx), .x_zero(cx_zero), .s_in(3'd0), .s_out(c_s2));

   function automatic int pw(input int q, input int e, input int m);
      int r = 1;
      for (int i = 0; i < e; i++) r = (r * q) % m;
      return r;
   endfunction

   // Discrete log by search; only called for nonzero v.
   function automatic int lg(input int v, input int q, input int m);
      for (int w = 0; w < m - 1; w++)
         if (pw(q, w, m) == v) return w;
      return 0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int coefs [3];
      int xs [24];
      rst_n = 1'b0; ld = 1'b0; cidx = '0; czero = 1'b1; xi = '0; xz = 1'b1; si = '0;
      cld = '0; cc_idx = '0; cc_zero = 1'b1; cx_idx = '0; cx_zero = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 output in reset", so, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 output after release", so, 0);
      chk("R1 chain output after release", c_s0, 0);

      // R1: no coefficient loaded yet, so the tap passes s_in through
      xz = 1'b0; xi = 3'(lg(4, Q1, M1)); si = 3'd3;
      #1;
      chk("R5 no change before edge", so, 0);
      tick();
      chk("R1 unloaded coefficient acts as zero", so, 3);

      // Exhaustive sweep on the modulus-7 tap
      for (int a = 0; a < M1; a++) begin
         ld = 1'b1; czero = (a == 0); cidx = (a == 0) ? 3'd0 : 3'(lg(a, Q1, M1));
         tick();
         ld = 1'b0;
         // R2: unrelated values on the load inputs while load is low
         cidx = 3'((cidx + 3) % (M1 - 1)); czero = ~czero;
         for (int x = 0; x < M1; x++) begin
            for (int s = 0; s < M1; s++) begin
               xz = (x == 0); xi = (x == 0) ? 3'd5 : 3'(lg(x, Q1, M1)); si = 3'(s);
               tick();
               if (a == 0 || x == 0)
                  chk("R4 R2 zero operand passes sum", so, s);
               else
                  chk("R3 R5 R2 product plus sum", so, (a * x + s) % M1);
               chk("R6 output below modulus", int'(so < 3'(M1)), 1);
            end
         end
      end

      // Three-tap chain, modulus 5; coefficient 3 at tap0 with x=4 gives the R3 example
      coefs[0] = 3; coefs[1] = 4; coefs[2] = 2;
      for (int k = 0; k < 3; k++) begin
         cld = 3'(1 << k); cc_zero = 1'b0; cc_idx = 2'(lg(coefs[k], Q2, M2));
         tick();
         cld = '0;
      end
      for (int n = 0; n < 24; n++) xs[n] = (n * 3 + 4) % M2;
      for (int n = 0; n < 24; n++) begin
         int y;
         cx_zero = (xs[n] == 0);
         cx_idx = (xs[n] == 0) ? 2'd1 : 2'(lg(xs[n], Q2, M2));
         tick();
         y = coefs[0] * xs[n];
         if (n >= 1) y += coefs[1] * xs[n-1];
         if (n >= 2) y += coefs[2] * xs[n-2];
         chk("R7 chain output", c_s0, y % M2);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule